// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Wakeup Bit

This block is the transmit half of an asynchronous serial link. A source hands it one data byte and one wakeup bit value over a valid/ready handshake. The block sends them as a single frame on a serial output that idles high. Bit timing comes from a one-cycle enable pulse, `tick`, that runs at a fixed multiple of the bit rate. Each serial bit lasts `OVS` such pulses.

Static configuration inputs control the frame layout:
- A wakeup slot can be added after the data bits. Multidrop receivers use it to tell address bytes from data bytes.
- A parity bit can be added, with even or odd sense.
- The frame can end with one or two stop bits.

An active-low clear-to-send input must be asserted before a frame can start. A frame that has already started always runs to its end.

Top module: `async_wake_tx`

## Requirements
- R1: After reset, `txd` is 1 and `busy` is 0. `in_ready` is 1 whenever the block is idle and `cts_n` is 0. While the block is idle, `txd` stays 1.
- R2: A frame starts with one start bit at 0. Next come the `DATA_W` data bits, least significant bit first. Then come the optional wakeup bit and optional parity bit, in that order. The frame ends with stop bits at 1.
- R3: Every bit of the frame, stop bits included, lasts exactly `OVS` `tick` pulses. `txd` changes only on a clock edge where `tick` is 1, except when a frame starts.
- R4: When `cfg_wake_en` is 1, a wakeup bit equal to `in_wake` is sent right after the last data bit. When `cfg_wake_en` is 0, there is no slot for it.
- R5: When `cfg_par_en` is 1, a parity bit follows the data bits and the wakeup bit (if present). With `cfg_par_odd` = 0, the count of ones across the data bits, the wakeup bit (if present) and the parity bit is even. With `cfg_par_odd` = 1, that count is odd.
- R6: `cfg_two_stop` = 1 sends two stop bits. `cfg_two_stop` = 0 sends one.
- R7: `in_ready` is 1 only when the block is idle and `cts_n` is 0. A cycle with `in_valid` and `in_ready` both 1 accepts the byte. On the next clock edge, `busy` becomes 1 and `txd` becomes 0.
- R8: While `cts_n` is 1, no new frame starts, even if `in_valid` is held high. If `cts_n` goes to 1 during a frame, the frame still completes unchanged.
- R9: The data byte, the wakeup value and all configuration inputs are captured when a frame is accepted. Changing them during the frame has no effect on that frame.
- R10: `busy` stays 1 from the start bit until the final `tick` of the last stop bit. It falls on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversampling enable, `OVS` pulses per bit |
| cfg_wake_en | input | 1 | Adds the wakeup bit slot |
| cfg_par_en | input | 1 | Adds the parity bit |
| cfg_par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cts_n | input | 1 | Clear-to-send, active low |
| in_valid | input | 1 | Source has a byte to send |
| in_data | input | DATA_W | Byte to send |
| in_wake | input | 1 | Wakeup bit value for this byte |
| in_ready | output | 1 | Block can accept a byte |
| txd | output | 1 | Serial output |
| busy | output | 1 | Frame in progress |

## Verification
The bench uses the default values, `DATA_W` = 8 and `OVS` = 16, and drives `tick` on every third clock. With these values, each sampled mid-bit point and each frame-end edge falls at a cycle that can be worked out exactly. The table of vectors covers all four frame lengths, from 10 to 13 bits, and both parity senses, both with and without the wakeup bit in the parity count. Directed tests then hold off a frame with clear-to-send, change every input during a frame, and reset in the middle of a frame.

// File: rtl/async_wake_tx.sv
module async_wake_tx #(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cfg_wake_en,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              cts_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_wake,
  output logic              in_ready,
  output logic              txd,
  output logic              busy
);
  localparam int FRAME_MAX = DATA_W + 5;
  localparam int CW        = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int NW        = $clog2(FRAME_MAX + 1);

  logic                 busy_q;
  logic [FRAME_MAX-1:0] sh_q;
  logic [FRAME_MAX-1:0] frame;
  logic [NW-1:0]        left_q;
  logic [NW-1:0]        nbits;
  logic [CW-1:0]        tcnt_q;
  logic                 par_bit;
  logic                 start;
  logic                 bit_end;

  assign par_bit  = (^in_data) ^ (cfg_wake_en & in_wake) ^ cfg_par_odd;
  assign nbits    = NW'(DATA_W + 2) + NW'(cfg_wake_en) + NW'(cfg_par_en) + NW'(cfg_two_stop);
  assign in_ready = !busy_q && !cts_n;
  assign start    = in_valid && in_ready;
  assign bit_end  = tick && (tcnt_q == CW'(OVS - 1));
  assign txd      = busy_q ? sh_q[0] : 1'b1;
  assign busy     = busy_q;

  always_comb begin
    frame              = '1;
    frame[0]           = 1'b0;
    frame[DATA_W:1]    = in_data;
    if (cfg_wake_en && cfg_par_en) begin
      frame[DATA_W+1]  = in_wake;
      frame[DATA_W+2]  = par_bit;
    end else if (cfg_wake_en) begin
      frame[DATA_W+1]  = in_wake;
    end else if (cfg_par_en) begin
      frame[DATA_W+1]  = par_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      tcnt_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      sh_q   <= frame;
      left_q <= nbits;
      tcnt_q <= '0;
    end else if (busy_q && tick) begin
      if (bit_end) begin
        tcnt_q <= '0;
        if (left_q == NW'(1)) begin
          busy_q <= 1'b0;
        end else begin
          sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
          left_q <= left_q - NW'(1);
        end
      end else begin
        tcnt_q <= tcnt_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/async_wake_tx_chk.sv
module async_wake_tx_chk #(
  parameter int OVS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic cts_n,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic busy
);
  int unsigned tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_cnt <= 0;
    else if (in_valid && in_ready) tick_cnt <= 0;
    else if (busy && tick) tick_cnt <= tick_cnt + 1;
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  assert_ready_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!busy && !cts_n));

  assert_start_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !txd));

  assert_tick_paced_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> ($stable(txd) && busy));

  assert_no_start_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cts_n) |=> !busy);

  assert_whole_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ((tick_cnt % OVS) == 0 && tick_cnt != 0));
endmodule

bind async_wake_tx async_wake_tx_chk #(.OVS(OVS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cts_n(cts_n),
  .in_valid(in_valid), .in_ready(in_ready), .txd(txd), .busy(busy)
);

// File: tb/tb_async_wake_tx.sv
module tb_async_wake_tx;
  localparam int DATA_W = 8;
  localparam int OVS    = 16;
  localparam int NVEC   = 8;
  // {wake_en, par_en, par_odd, two_stop, data[7:0], wake}
  localparam logic [12:0] VEC [NVEC] = '{
    {4'b0000, 8'hA5, 1'b0},
    {4'b1000, 8'h3C, 1'b1},
    {4'b0100, 8'h01, 1'b0},
    {4'b0110, 8'h01, 1'b0},
    {4'b1110, 8'hFF, 1'b1},
    {4'b1101, 8'h80, 1'b1},
    {4'b0001, 8'h00, 1'b0},
    {4'b1111, 8'h7E, 1'b0}
  };

  logic clk = 0, rst_n = 0, tick = 0;
  logic cfg_wake_en = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0;
  logic cts_n = 0, in_valid = 0, in_wake = 0;
  logic [DATA_W-1:0] in_data = '0;
  logic in_ready, txd, busy;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  initial begin
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      tick <= (ph == 2);
      ph = (ph == 2) ? 0 : ph + 1;
    end
  end

  async_wake_tx #(.DATA_W(DATA_W), .OVS(OVS)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_wake_en(cfg_wake_en),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .cts_n(cts_n), .in_valid(in_valid), .in_data(in_data), .in_wake(in_wake),
    .in_ready(in_ready), .txd(txd), .busy(busy)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [3:0] c);
    return DATA_W + 2 + int'(c[3]) + int'(c[2]) + int'(c[0]);
  endfunction

  function automatic logic [15:0] exp_bits(input logic [3:0] c, input logic [7:0] d, input logic w);
    logic [15:0] b;
    int i;
    logic ones;
    b = '1;
    b[0] = 1'b0;
    ones = 1'b0;
    for (int k = 0; k < DATA_W; k++) begin
      b[1+k] = d[k];
      ones ^= d[k];
    end
    i = DATA_W + 1;
    if (c[3]) begin
      b[i] = w;
      ones ^= w;
      i++;
    end
    if (c[2]) b[i] = ones ^ c[1];
    return b;
  endfunction

  task automatic wait_ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic send_frame(input logic [3:0] c, input logic [7:0] d, input logic w, input bit perturb);
    logic [15:0] eb;
    int n;
    int guard;
    eb = exp_bits(c, d, w);
    n  = exp_len(c);
    @(negedge clk);
    {cfg_wake_en, cfg_par_en, cfg_par_odd, cfg_two_stop} = c;
    in_data = d; in_wake = w; in_valid = 1;
    guard = 0;
    while (!in_ready && guard < 1000) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    check(busy && !txd && !in_ready, "R7", {busy, txd, in_ready}, 3'b100);
    in_valid = 0;
    if (perturb) begin
      {cfg_wake_en, cfg_par_en, cfg_par_odd, cfg_two_stop} = ~c;
      in_data = ~d; in_wake = ~w; cts_n = 1;
    end
    for (int b = 0; b < n; b++) begin
      wait_ticks(OVS / 2);
      @(negedge clk);
      check(txd == eb[b], perturb ? "R9" : (b == 0 ? "R2" : (b > DATA_W ? "R4/R5/R6" : "R2")), txd, eb[b]);
      check(busy, "R3", busy, 1);
      if (b == n - 1) begin
        wait_ticks(OVS - OVS / 2 - 1);
        @(negedge clk);
        check(busy, "R10", busy, 1);
        wait_ticks(1);
      end else begin
        wait_ticks(OVS - OVS / 2);
      end
    end
    @(negedge clk);
    check(!busy && txd, "R10", {busy, txd}, 2'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txd && !busy, "R1", {txd, busy}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    check(txd && !busy && in_ready, "R1", {txd, busy, in_ready}, 3'b101);

    for (int v = 0; v < NVEC; v++)
      send_frame(VEC[v][12:9], VEC[v][8:1], VEC[v][0], 1'b0);

    // R8: clear-to-send high holds off a pending byte
    @(negedge clk);
    cts_n = 1; in_valid = 1; in_data = 8'h55;
    repeat (80) @(negedge clk);
    check(!busy && txd && !in_ready, "R8", {busy, txd, in_ready}, 3'b010);
    in_valid = 0;
    cts_n = 0;
    send_frame(4'b0100, 8'h55, 1'b0, 1'b0);

    // R9 and R8: inputs flip and cts_n rises mid-frame
    send_frame(4'b1010, 8'hC3, 1'b1, 1'b1);
    check(!in_ready, "R8", in_ready, 0);
    cts_n = 0;
    @(negedge clk);
    check(in_ready, "R7", in_ready, 1);

    // R1: reset in the middle of a frame
    in_valid = 1; in_data = 8'h00;
    {cfg_wake_en, cfg_par_en, cfg_par_odd, cfg_two_stop} = 4'b0000;
    @(negedge clk);
    in_valid = 0;
    wait_ticks(20);
    @(negedge clk);
    check(busy, "R10", busy, 1);
    rst_n = 0;
    @(negedge clk);
    check(!busy && txd, "R1", {busy, txd}, 2'b01);
    rst_n = 1;
    @(negedge clk);
    send_frame(4'b1100, 8'h0F, 1'b1, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule